// File: doc/BRIEF.md
# Audio Buffer Address and Interrupt Controller

This block keeps the control and status word for an audio port that streams samples through circular buffers in memory. There is one playback channel and one capture channel. Each channel keeps a current word address. It starts at a begin address, steps by one word on every advance strobe from the bus master, and goes back to the begin address after it has reached the end address.

When an advance lands on the buffer's midpoint or on its end address, the channel raises a sticky flag. Software clears the flag by writing a one to its bit. Each flag drives its own interrupt line through an inverter, so the line is active-low. The same word also holds enable bits for two audio link types, a select that routes the shared pins, and a FIFO threshold select. The threshold select sets the occupancy level at which each channel's FIFO requests service.

The serial protocols, the memory and the bus master are outside this block. The begin and end addresses are inputs, which software is expected to keep stable while the channel runs.

Top module: `aud_dma_irq_ctrl`

## Requirements
- R1: After synchronous reset the status word reads 0, each current address equals its begin address, and both interrupt lines are high.
- R2: Each advance strobe moves the current address up by one word, and without a strobe the address holds its value.
- R3: An advance taken while the current address equals the end address loads the begin address.
- R4: A channel's flag sets on an advance whose new address equals the midpoint, computed as ((end - begin) - 1) / 2 + begin with integer division.
- R5: A channel's flag sets on an advance whose new address equals the end address. Both flags stay set until cleared.
- R6: Writing the status word with bit 6 = 1 clears the playback flag and with bit 7 = 1 clears the capture flag. A 0 in those bits leaves the flag unchanged.
- R7: When a flag-setting advance and a write-one clear of the same flag fall in the same cycle, the flag ends up set.
- R8: A flag sets only on the advance that reaches a match. Staying at a matching address after a clear does not set it again.
- R9: Each channel has its own interrupt output. It is low exactly while that channel's flag is set.
- R10: In the status word, bit 1 enables the serial interface and bit 2 enables the link interface, independently. Bit 8 routes the pins (0 = serial, 1 = link) and bit 4 selects the threshold. Writes load these bits. Every other bit apart from the two flags reads 0.
- R11: With threshold select 0 the level is 8, and with 1 it is 4. The playback request is high when its occupancy is at or below the level. The capture request is high when its occupancy is at or above the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the status word |
| csr_wdata | input | 16 | Write data |
| csr_rdata | output | 16 | Status word readback |
| tx_begin | input | ADDR_W | Playback buffer begin address (words) |
| tx_end | input | ADDR_W | Playback buffer end address (words) |
| rx_begin | input | ADDR_W | Capture buffer begin address (words) |
| rx_end | input | ADDR_W | Capture buffer end address (words) |
| tx_adv | input | 1 | Playback address advance strobe |
| rx_adv | input | 1 | Capture address advance strobe |
| tx_cur | output | ADDR_W | Playback current address |
| rx_cur | output | ADDR_W | Capture current address |
| tx_irq_n | output | 1 | Playback interrupt, active-low |
| rx_irq_n | output | 1 | Capture interrupt, active-low |
| tx_level | input | LVL_W | Playback FIFO occupancy |
| rx_level | input | LVL_W | Capture FIFO occupancy |
| tx_fifo_req | output | 1 | Playback FIFO service request |
| rx_fifo_req | output | 1 | Capture FIFO service request |
| ser_en | output | 1 | Serial interface enable |
| link_en | output | 1 | Link interface enable |
| pins_to_link | output | 1 | Shared pins routed to the link interface |

## Verification
On every cycle, the in-line properties check the single-word step, the hold without a strobe, the wrap from end to begin, and that a flag rises only on a cycle with an advance. They also check that a clear without an advance leaves the flag low, that a write loads the enable field, and that reserved write bits never appear in the readback. Other behaviour can only be shown by the bench's scenarios, which follow a model of the address and flag through whole laps of both buffers. That covers whether the flag fires at exactly the midpoint and end addresses, the sticky behaviour across a wrap, set winning over a clear in the same cycle, and the threshold levels for each select value.

// File: rtl/aud_dma_pkg.sv
// Package: shared widths, bit positions and the control field type for the
// audio buffer controller. Assumes a 16-bit status word.
package aud_dma_pkg;

    localparam int CSR_W       = 16;
    localparam int BIT_SER_EN  = 1;
    localparam int BIT_LINK_EN = 2;
    localparam int BIT_THR_SEL = 4;
    localparam int BIT_TX_FLAG = 6;
    localparam int BIT_RX_FLAG = 7;
    localparam int BIT_PIN_SEL = 8;

    typedef struct packed {
        logic       pin_to_link;
        logic       thr_small;
        logic       link_en;
        logic       ser_en;
    } aud_ctrl_t;

endpackage

// File: rtl/aud_dma_chan.sv
// Module: one channel's circular address tracker and sticky flag.
// The current address steps one word per advance and wraps from end to begin.
// The flag sets when an advance lands on the midpoint or on the end address.
// Assumes begin <= end and that both stay stable while the channel runs.
module aud_dma_chan #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] buf_begin,
    input  logic [ADDR_W-1:0] buf_end,
    input  logic              adv,
    input  logic              clr,
    output logic [ADDR_W-1:0] cur,
    output logic              flag
);

    logic [ADDR_W-1:0] span_m1;
    logic [ADDR_W-1:0] mid_addr;
    logic [ADDR_W-1:0] nxt_addr;
    logic              hit;

    // Midpoint and next address, plus whether this advance reaches a match.
    always_comb begin
        span_m1  = buf_end - buf_begin - ADDR_W'(1);
        mid_addr = (span_m1 >> 1) + buf_begin;
        nxt_addr = (cur == buf_end) ? buf_begin : cur + ADDR_W'(1);
        hit      = adv && ((nxt_addr == mid_addr) || (nxt_addr == buf_end));
    end

    // Current address register: load begin on reset, step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= buf_begin;
        end else if (adv) begin
            cur <= nxt_addr;
        end
    end

    // Sticky flag: a set event takes priority over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cur != buf_end) |=> cur == $past(cur) + ADDR_W'(1));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cur));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cur == buf_end) |=> cur == $past(buf_begin));

    p_rise_on_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(adv));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !adv) |=> !flag);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!flag || $past(adv)));

endmodule

// File: rtl/aud_fifo_req.sv
// Module: FIFO service request from occupancy against a selectable level.
// DRAIN=1 requests at or above the level (capture side). DRAIN=0 requests
// at or below it (playback side). Assumes occupancy is a plain count.
module aud_fifo_req #(
    parameter int LVL_W  = 5,
    parameter int THR_HI = 8,
    parameter int THR_LO = 4,
    parameter bit DRAIN  = 1'b1
) (
    input  logic [LVL_W-1:0] level,
    input  logic             thr_small,
    output logic             req
);

    logic [LVL_W-1:0] thr;

    // Pick the active level from the select bit.
    always_comb begin
        thr = thr_small ? LVL_W'(THR_LO) : LVL_W'(THR_HI);
    end

    generate
        if (DRAIN) begin : g_drain
            // Capture: ask for draining once enough data is held.
            always_comb req = (level >= thr);
        end else begin : g_fill
            // Playback: ask for refill once occupancy has fallen low.
            always_comb req = (level <= thr);
        end
    endgenerate

endmodule

// File: rtl/aud_ctrl_regs.sv
// Module: control and status word. It holds the enables, the pin route and
// the threshold select. It decodes write-one-to-clear strobes for the two
// channel flags and assembles the readback. Reserved bits read zero.
module aud_ctrl_regs
    import aud_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CSR_W-1:0] wdata,
    input  logic             tx_flag,
    input  logic             rx_flag,
    output aud_ctrl_t        ctrl,
    output logic             tx_clr,
    output logic             rx_clr,
    output logic [CSR_W-1:0] rdata
);

    // Control fields: cleared on reset, loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl.pin_to_link <= wdata[BIT_PIN_SEL];
            ctrl.thr_small   <= wdata[BIT_THR_SEL];
            ctrl.link_en     <= wdata[BIT_LINK_EN];
            ctrl.ser_en      <= wdata[BIT_SER_EN];
        end
    end

    // Write-one-to-clear strobes for the flags.
    always_comb begin
        tx_clr = wr && wdata[BIT_TX_FLAG];
        rx_clr = wr && wdata[BIT_RX_FLAG];
    end

    // Readback word: only the defined bits are driven.
    always_comb begin
        rdata              = '0;
        rdata[BIT_PIN_SEL] = ctrl.pin_to_link;
        rdata[BIT_RX_FLAG] = rx_flag;
        rdata[BIT_TX_FLAG] = tx_flag;
        rdata[BIT_THR_SEL] = ctrl.thr_small;
        rdata[BIT_LINK_EN] = ctrl.link_en;
        rdata[BIT_SER_EN]  = ctrl.ser_en;
    end

    p_en_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> {ctrl.link_en, ctrl.ser_en} == $past(wdata[BIT_LINK_EN:BIT_SER_EN]));

    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && |{wdata[CSR_W-1:BIT_PIN_SEL+1], wdata[5], wdata[3], wdata[0]})
        |=> (rdata[CSR_W-1:BIT_PIN_SEL+1] == '0 && rdata[5] == 1'b0
             && rdata[3] == 1'b0 && rdata[0] == 1'b0));

endmodule

// File: rtl/aud_dma_irq_ctrl.sv
// Module: top of the audio buffer controller. It holds the control word, two
// circular address channels (playback index 0, capture index 1), their
// active-low interrupt lines and two FIFO request comparators.
// Assumes the begin and end inputs stay stable while the channels run.
module aud_dma_irq_ctrl
    import aud_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LVL_W  = 5,
    parameter int THR_HI = 8,
    parameter int THR_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic [ADDR_W-1:0] tx_begin,
    input  logic [ADDR_W-1:0] tx_end,
    input  logic [ADDR_W-1:0] rx_begin,
    input  logic [ADDR_W-1:0] rx_end,
    input  logic              tx_adv,
    input  logic              rx_adv,
    output logic [ADDR_W-1:0] tx_cur,
    output logic [ADDR_W-1:0] rx_cur,
    output logic              tx_irq_n,
    output logic              rx_irq_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              tx_fifo_req,
    output logic              rx_fifo_req,
    output logic              ser_en,
    output logic              link_en,
    output logic              pins_to_link
);

    localparam int N_CH = 2;

    aud_ctrl_t         ctrl;
    logic [N_CH-1:0]   ch_clr;
    logic [N_CH-1:0]   ch_flag;
    logic [N_CH-1:0]   ch_adv;
    logic [ADDR_W-1:0] ch_begin [N_CH];
    logic [ADDR_W-1:0] ch_end   [N_CH];
    logic [ADDR_W-1:0] ch_cur   [N_CH];

    aud_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (csr_wr),
        .wdata   (csr_wdata),
        .tx_flag (ch_flag[0]),
        .rx_flag (ch_flag[1]),
        .ctrl    (ctrl),
        .tx_clr  (ch_clr[0]),
        .rx_clr  (ch_clr[1]),
        .rdata   (csr_rdata)
    );

    // Gather per-channel inputs into arrays indexed by channel.
    always_comb begin
        ch_adv      = {rx_adv, tx_adv};
        ch_begin[0] = tx_begin;
        ch_begin[1] = rx_begin;
        ch_end[0]   = tx_end;
        ch_end[1]   = rx_end;
    end

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_chan
            aud_dma_chan #(.ADDR_W(ADDR_W)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .buf_begin (ch_begin[c]),
                .buf_end   (ch_end[c]),
                .adv       (ch_adv[c]),
                .clr       (ch_clr[c]),
                .cur       (ch_cur[c]),
                .flag      (ch_flag[c])
            );
        end
    endgenerate

    aud_fifo_req #(.LVL_W(LVL_W), .THR_HI(THR_HI), .THR_LO(THR_LO), .DRAIN(1'b0)) u_tx_req (
        .level     (tx_level),
        .thr_small (ctrl.thr_small),
        .req       (tx_fifo_req)
    );

    aud_fifo_req #(.LVL_W(LVL_W), .THR_HI(THR_HI), .THR_LO(THR_LO), .DRAIN(1'b1)) u_rx_req (
        .level     (rx_level),
        .thr_small (ctrl.thr_small),
        .req       (rx_fifo_req)
    );

    // Drive the outputs: addresses, inverted flags and control fields.
    always_comb begin
        tx_cur       = ch_cur[0];
        rx_cur       = ch_cur[1];
        tx_irq_n     = ~ch_flag[0];
        rx_irq_n     = ~ch_flag[1];
        ser_en       = ctrl.ser_en;
        link_en      = ctrl.link_en;
        pins_to_link = ctrl.pin_to_link;
    end

endmodule

// File: tb/aud_dma_irq_ctrl_bench.sv
// Scoreboard bench. Driver tasks drive inputs just after a rising edge, update
// a requirement-level model and queue the expected outputs. A monitor pops the
// queue on falling edges and compares.
module aud_dma_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int LW = 5;
    localparam logic [AW-1:0] TXB = 16'd16;
    localparam logic [AW-1:0] TXE = 16'd25;
    localparam logic [AW-1:0] RXB = 16'd100;
    localparam logic [AW-1:0] RXE = 16'd107;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csr_wr = 1'b0;
    logic [15:0] csr_wdata = '0;
    logic [15:0] csr_rdata;
    logic tx_adv = 1'b0, rx_adv = 1'b0;
    logic [AW-1:0] tx_cur, rx_cur;
    logic tx_irq_n, rx_irq_n;
    logic [LW-1:0] tx_level = '0, rx_level = '0;
    logic tx_fifo_req, rx_fifo_req, ser_en, link_en, pins_to_link;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_dma_irq_ctrl u_aud_dma_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .tx_begin(TXB), .tx_end(TXE), .rx_begin(RXB),
        .rx_end(RXE), .tx_adv(tx_adv), .rx_adv(rx_adv), .tx_cur(tx_cur),
        .rx_cur(rx_cur), .tx_irq_n(tx_irq_n), .rx_irq_n(rx_irq_n),
        .tx_level(tx_level), .rx_level(rx_level), .tx_fifo_req(tx_fifo_req),
        .rx_fifo_req(rx_fifo_req), .ser_en(ser_en), .link_en(link_en),
        .pins_to_link(pins_to_link)
    );

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        int          req;
    } sb_item_t;

    sb_item_t sb[$];
    sb_item_t it;
    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Model state, built from the requirements.
    logic [AW-1:0] m_tx_cur, m_rx_cur;
    logic m_tx_flag, m_rx_flag;
    logic m_pin, m_thr, m_link, m_ser;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] probe(int sel);
        case (sel)
            0: return {16'h0, csr_rdata};
            1: return {16'h0, tx_cur};
            2: return {16'h0, rx_cur};
            3: return {31'h0, tx_irq_n};
            4: return {31'h0, rx_irq_n};
            5: return {31'h0, tx_fifo_req};
            6: return {31'h0, rx_fifo_req};
            7: return {31'h0, ser_en};
            8: return {31'h0, link_en};
            default: return {31'h0, pins_to_link};
        endcase
    endfunction

    function automatic string sel_name(int sel);
        case (sel)
            0: return "csr_rdata";
            1: return "tx_cur";
            2: return "rx_cur";
            3: return "tx_irq_n";
            4: return "rx_irq_n";
            5: return "tx_fifo_req";
            6: return "rx_fifo_req";
            7: return "ser_en";
            8: return "link_en";
            default: return "pins_to_link";
        endcase
    endfunction

    // Monitor: compare every queued item that is due at this falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            it = sb.pop_front();
            n_checks++;
            if (probe(it.sel) !== it.exp) begin
                n_errors++;
                $display("FAIL R%0d %s actual=%0h expected=%0h", it.req,
                         sel_name(it.sel), probe(it.sel), it.exp);
            end
        end
    end

    task automatic push(int sel, logic [31:0] exp, int req);
        sb_item_t x;
        x.due = cyc; x.sel = sel; x.exp = exp; x.req = req;
        sb.push_back(x);
    endtask

    function automatic logic [AW-1:0] mid_of(logic [AW-1:0] b, logic [AW-1:0] e);
        return ((e - b - 16'd1) / 2) + b;
    endfunction

    function automatic logic [15:0] m_word();
        return {7'h0, m_pin, m_rx_flag, m_tx_flag, 1'b0, m_thr, 1'b0, m_link, m_ser, 1'b0};
    endfunction

    task automatic expect_all(int req);
        push(0, {16'h0, m_word()}, req);
        push(1, {16'h0, m_tx_cur}, req);
        push(2, {16'h0, m_rx_cur}, req);
        push(3, {31'h0, ~m_tx_flag}, req);
        push(4, {31'h0, ~m_rx_flag}, req);
    endtask

    // Driver: one cycle of stimulus, model update, queued expectations.
    task automatic step(logic t, logic r, logic w, logic [15:0] d, int req);
        logic [AW-1:0] nt, nr;
        logic ht, hr;
        tx_adv = t; rx_adv = r; csr_wr = w; csr_wdata = d;
        @(posedge clk); #1;
        tx_adv = 1'b0; rx_adv = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
        nt = (m_tx_cur == TXE) ? TXB : m_tx_cur + 16'd1;
        nr = (m_rx_cur == RXE) ? RXB : m_rx_cur + 16'd1;
        ht = t && (nt == mid_of(TXB, TXE) || nt == TXE);
        hr = r && (nr == mid_of(RXB, RXE) || nr == RXE);
        if (t) m_tx_cur = nt;
        if (r) m_rx_cur = nr;
        m_tx_flag = ht ? 1'b1 : ((w && d[6]) ? 1'b0 : m_tx_flag);
        m_rx_flag = hr ? 1'b1 : ((w && d[7]) ? 1'b0 : m_rx_flag);
        if (w) begin
            m_pin = d[8]; m_thr = d[4]; m_link = d[2]; m_ser = d[1];
        end
        expect_all(req);
    endtask

    task automatic level_check(logic [LW-1:0] tl, logic [LW-1:0] rl,
                               logic te, logic re);
        tx_level = tl; rx_level = rl;
        push(5, {31'h0, te}, 11);  // R11 playback request
        push(6, {31'h0, re}, 11);  // R11 capture request
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL R0 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        m_tx_cur = TXB; m_rx_cur = RXB; m_tx_flag = 1'b0; m_rx_flag = 1'b0;
        m_pin = 1'b0; m_thr = 1'b0; m_link = 1'b0; m_ser = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_all(1);                                   // R1 reset state
        push(7, 32'h0, 1); push(8, 32'h0, 1); push(9, 32'h0, 1);  // R1
        repeat (3) step(1'b1, 1'b0, 1'b0, 16'h0, 2);     // R2 17..19
        step(1'b0, 1'b0, 1'b0, 16'h0, 2);                // R2 hold
        step(1'b1, 1'b0, 1'b0, 16'h0, 4);                // R4 midpoint 20, R9
        step(1'b0, 1'b0, 1'b1, 16'h0000, 6);             // R6 zero keeps flag
        step(1'b0, 1'b0, 1'b1, 16'h0040, 6);             // R6 clear
        repeat (2) step(1'b0, 1'b0, 1'b0, 16'h0, 8);     // R8 no re-set at 20
        repeat (4) step(1'b1, 1'b0, 1'b0, 16'h0, 2);     // R2 21..24
        step(1'b1, 1'b0, 1'b0, 16'h0, 5);                // R5 end 25
        step(1'b1, 1'b0, 1'b0, 16'h0, 3);                // R3 wrap to 16
        step(1'b0, 1'b0, 1'b1, 16'h0040, 6);             // R6 clear
        repeat (8) step(1'b1, 1'b0, 1'b0, 16'h0, 4);     // R4 lap to 24
        step(1'b1, 1'b0, 1'b1, 16'h0040, 7);             // R7 set beats clear
        step(1'b0, 1'b0, 1'b1, 16'h0040, 6);             // R6
        repeat (3) step(1'b0, 1'b1, 1'b0, 16'h0, 4);     // R4 capture mid 103
        step(1'b0, 1'b1, 1'b1, 16'h0080, 6);             // R6 capture clear
        repeat (3) step(1'b0, 1'b1, 1'b0, 16'h0, 5);     // R5 capture end 107
        step(1'b1, 1'b1, 1'b0, 16'h0, 3);                // R3 capture wrap, R9
        step(1'b0, 1'b0, 1'b1, 16'h0116, 10);            // R10 all fields
        push(7, 32'h1, 10); push(8, 32'h1, 10); push(9, 32'h1, 10);
        step(1'b0, 1'b0, 1'b1, 16'h0002, 10);            // R10 enables independent
        push(7, 32'h1, 10); push(8, 32'h0, 10); push(9, 32'h0, 10);
        step(1'b0, 1'b0, 1'b1, 16'h0004, 10);            // R10
        push(7, 32'h0, 10); push(8, 32'h1, 10);
        step(1'b0, 1'b0, 1'b1, 16'hFEE9, 10);            // R10 reserved read zero
        step(1'b0, 1'b0, 1'b1, 16'h0000, 11);            // R11 level 8
        level_check(5'd8, 5'd7, 1'b1, 1'b0);
        level_check(5'd9, 5'd8, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1, 16'h0010, 11);            // R11 level 4
        level_check(5'd4, 5'd4, 1'b1, 1'b1);
        level_check(5'd5, 5'd3, 1'b0, 1'b0);
        @(negedge clk); #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule